// File: doc/BRIEF.md
# Calendar Next-Date Generator

This block holds a calendar date made of three fields: month (1 to 12), day of month (1 to 31) and weekday (1 = Sunday up to 7 = Saturday). It also presents the following day's date at all times. A combinational core produces the successor date. The weekday wheel in that core is completely separate from the month/day wheel, which uses a per-month length table and wraps at the year end. A leap flag input stretches February to 29 days.

A registered stage around the core keeps the current date. A load strobe writes an arbitrary date into it. An advance enable replaces the stored date with its successor, one step per cycle. A validity output reports whether the stored date is a legal calendar date. Year counting is left to the surrounding logic, and so is deciding which years are leap years.

Top module: `date_stepper`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) sets the stored date to month 1, day 1, weekday 1 (Sunday).
- R2: The next weekday is 1 when the stored weekday is 7, and otherwise the stored weekday plus one. It does not depend on month, day of month or leap.
- R3: Months 4, 6, 9 and 11 last 30 days. February lasts 28 days when leap is low. All other months last 31 days.
- R4: With leap high, February lasts 29 days: Feb 28 steps to Feb 29, and Feb 29 steps to Mar 1.
- R5: On the last day of months 1 to 11, the next date is day 1 of the following month.
- R6: The date December 31 steps to January 1.
- R7: When the day is before the month's last day, the next day of month is the day plus one and the month is unchanged.
- R8: A load strobe stores the load date at the next edge. If load and advance are high in the same cycle, the load date is stored and the advance has no effect.
- R9: With advance high and load low, the stored date becomes the presented next date at the edge. With both low, the stored date holds.
- R10: cur_valid is high only when month is 1 to 12, day is 1 to the month's length (leap-aware) and weekday is 1 to 7.
- R11: The next-date outputs follow the stored date and the leap input combinationally, within the same cycle.
- R12: For illegal dates the successor is still fixed: a day at or beyond the month length counts as the last day, month 12 or above wraps to 1, month 0 and months 13 to 15 last 31 days, and weekday 0 steps to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| leap | input | 1 | February has 29 days when high |
| load | input | 1 | Store the load date at the next edge |
| ld_month | input | 4 | Month to load |
| ld_dom | input | 5 | Day of month to load |
| ld_dow | input | 3 | Weekday to load |
| advance | input | 1 | Step the stored date by one day |
| cur_month | output | 4 | Stored month |
| cur_dom | output | 5 | Stored day of month |
| cur_dow | output | 3 | Stored weekday |
| cur_valid | output | 1 | Stored date is legal |
| nxt_month | output | 4 | Month of the following day |
| nxt_dom | output | 5 | Day of month of the following day |
| nxt_dow | output | 3 | Weekday of the following day |

## Verification
A load and an advance can be requested in the same cycle. The bench drives both strobes together on a date whose successor differs from the load date in every field. It then expects the stored value to be exactly the load date, not its successor and not a mix of the two. Leap changes that arrive while the date is held are a second overlap. The bench toggles leap on a stored Feb 28 with no step and judges whether the presented next date switches between Mar 1 and Feb 29 in that same cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int unsigned MON_W     = 4;
   localparam int unsigned DAY_W     = 5;
   localparam int unsigned WKD_W     = 3;
   localparam int unsigned WKD_FIRST = 1;
   localparam int unsigned WKD_LAST  = 7;
   localparam int unsigned MONTHS    = 12;
endpackage

// File: rtl/dow_successor.sv
module dow_successor #(
   parameter int unsigned W     = cal_pkg::WKD_W,
   parameter int unsigned FIRST = cal_pkg::WKD_FIRST,
   parameter int unsigned LAST  = cal_pkg::WKD_LAST
) (
   input  logic [W-1:0] wkd_i,
   output logic [W-1:0] wkd_o
);
   localparam logic [W-1:0] FIRST_V = W'(FIRST);
   localparam logic [W-1:0] LAST_V  = W'(LAST);

   // wraps at the last weekday; anything outside the wheel restarts it
   assign wkd_o = (wkd_i >= LAST_V || wkd_i < FIRST_V) ? FIRST_V : wkd_i + W'(1);
endmodule

// File: rtl/month_length.sv
module month_length #(
   parameter int unsigned MW      = cal_pkg::MON_W,
   parameter int unsigned DW      = cal_pkg::DAY_W,
   parameter bit          LEAP_EN = 1'b1
) (
   input  logic [MW-1:0] mon_i,
   input  logic          leap_i,
   output logic [DW-1:0] len_o
);
   logic [DW-1:0] feb_len;

   generate
      if (LEAP_EN) begin : g_leap
         assign feb_len = leap_i ? DW'(29) : DW'(28);
      end else begin : g_noleap
         logic unused_leap;
         assign unused_leap = leap_i;
         assign feb_len     = DW'(28);
      end
   endgenerate

   always_comb begin
      if (mon_i == MW'(2))
         len_o = feb_len;
      else if (mon_i == MW'(4) || mon_i == MW'(6) || mon_i == MW'(9) || mon_i == MW'(11))
         len_o = DW'(30);
      else
         len_o = DW'(31);
   end
endmodule

// File: rtl/next_date_core.sv
module next_date_core #(
   parameter int unsigned MW        = cal_pkg::MON_W,
   parameter int unsigned DW        = cal_pkg::DAY_W,
   parameter int unsigned WW        = cal_pkg::WKD_W,
   parameter int unsigned WK_FIRST  = cal_pkg::WKD_FIRST,
   parameter int unsigned WK_LAST   = cal_pkg::WKD_LAST,
   parameter int unsigned NUM_MONTH = cal_pkg::MONTHS,
   parameter bit          LEAP_EN   = 1'b1
) (
   input  logic [MW-1:0] mon_i,
   input  logic [DW-1:0] dom_i,
   input  logic [WW-1:0] wkd_i,
   input  logic          leap_i,
   output logic [MW-1:0] mon_o,
   output logic [DW-1:0] dom_o,
   output logic [WW-1:0] wkd_o,
   output logic          legal_o
);
   localparam logic [MW-1:0] LAST_MON = MW'(NUM_MONTH);

   logic [DW-1:0] len;
   logic          end_of_month;
   logic          end_of_year;

   dow_successor #(.W(WW), .FIRST(WK_FIRST), .LAST(WK_LAST)) u_wheel (
      .wkd_i (wkd_i),
      .wkd_o (wkd_o)
   );

   month_length #(.MW(MW), .DW(DW), .LEAP_EN(LEAP_EN)) u_len (
      .mon_i  (mon_i),
      .leap_i (leap_i),
      .len_o  (len)
   );

   assign end_of_month = (dom_i >= len);
   assign end_of_year  = (mon_i >= LAST_MON);

   assign dom_o = end_of_month ? DW'(1) : dom_i + DW'(1);
   assign mon_o = !end_of_month ? mon_i : (end_of_year ? MW'(1) : mon_i + MW'(1));

   assign legal_o = (mon_i != '0) && (mon_i <= LAST_MON) &&
                    (dom_i != '0) && (dom_i <= len) &&
                    (wkd_i >= WW'(WK_FIRST)) && (wkd_i <= WW'(WK_LAST));
endmodule

// File: rtl/date_stepper.sv
module date_stepper #(
   parameter int unsigned MW        = cal_pkg::MON_W,
   parameter int unsigned DW        = cal_pkg::DAY_W,
   parameter int unsigned WW        = cal_pkg::WKD_W,
   parameter int unsigned WK_FIRST  = cal_pkg::WKD_FIRST,
   parameter int unsigned WK_LAST   = cal_pkg::WKD_LAST,
   parameter int unsigned NUM_MONTH = cal_pkg::MONTHS,
   parameter bit          LEAP_EN   = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          leap,
   input  logic          load,
   input  logic [MW-1:0] ld_month,
   input  logic [DW-1:0] ld_dom,
   input  logic [WW-1:0] ld_dow,
   input  logic          advance,
   output logic [MW-1:0] cur_month,
   output logic [DW-1:0] cur_dom,
   output logic [WW-1:0] cur_dow,
   output logic          cur_valid,
   output logic [MW-1:0] nxt_month,
   output logic [DW-1:0] nxt_dom,
   output logic [WW-1:0] nxt_dow
);
   generate
      if (MW < 4) begin : g_bad_mw
         $error("date_stepper: MW must hold month 12");
      end
      if (DW < 5) begin : g_bad_dw
         $error("date_stepper: DW must hold day 31");
      end
      if (WK_LAST <= WK_FIRST || WK_LAST >= (1 << WW)) begin : g_bad_wk
         $error("date_stepper: weekday range does not fit WW");
      end
   endgenerate

   next_date_core #(
      .MW(MW), .DW(DW), .WW(WW), .WK_FIRST(WK_FIRST), .WK_LAST(WK_LAST),
      .NUM_MONTH(NUM_MONTH), .LEAP_EN(LEAP_EN)
   ) u_core (
      .mon_i   (cur_month),
      .dom_i   (cur_dom),
      .wkd_i   (cur_dow),
      .leap_i  (leap),
      .mon_o   (nxt_month),
      .dom_o   (nxt_dom),
      .wkd_o   (nxt_dow),
      .legal_o (cur_valid)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cur_month <= MW'(1);
         cur_dom   <= DW'(1);
         cur_dow   <= WW'(WK_FIRST);
      end else if (load) begin
         cur_month <= ld_month;
         cur_dom   <= ld_dom;
         cur_dow   <= ld_dow;
      end else if (advance) begin
         cur_month <= nxt_month;
         cur_dom   <= nxt_dom;
         cur_dow   <= nxt_dow;
      end
   end

   // R1
   reset_date_chk: assert property (@(posedge clk)
      rst |=> (cur_month == MW'(1) && cur_dom == DW'(1) && cur_dow == WW'(WK_FIRST)));

   // R8
   load_wins_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> (cur_month == $past(ld_month) && cur_dom == $past(ld_dom) &&
                cur_dow == $past(ld_dow)));

   // R9
   step_take_chk: assert property (@(posedge clk) disable iff (rst)
      (advance && !load) |=> (cur_month == $past(nxt_month) && cur_dom == $past(nxt_dom) &&
                              cur_dow == $past(nxt_dow)));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!advance && !load) |=> ($stable(cur_month) && $stable(cur_dom) && $stable(cur_dow)));

   // R2
   wkd_range_chk: assert property (@(posedge clk) disable iff (rst)
      (nxt_dow >= WW'(WK_FIRST) && nxt_dow <= WW'(WK_LAST)));

   // R6
   year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (cur_month == MW'(NUM_MONTH) && cur_dom == DW'(31)) |->
         (nxt_month == MW'(1) && nxt_dom == DW'(1)));
endmodule

// File: tb/date_stepper_test.sv
module date_stepper_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       leap = 1'b0;
   logic       load = 1'b0;
   logic [3:0] ld_month = '0;
   logic [4:0] ld_dom = '0;
   logic [2:0] ld_dow = '0;
   logic       advance = 1'b0;
   logic [3:0] cur_month, nxt_month;
   logic [4:0] cur_dom, nxt_dom;
   logic [2:0] cur_dow, nxt_dow;
   logic       cur_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int m_mon = 1, m_dom = 1, m_wkd = 1;

   always #(CLK_PERIOD/2) clk = ~clk;

   date_stepper uut (
      .clk(clk), .rst(rst), .leap(leap), .load(load),
      .ld_month(ld_month), .ld_dom(ld_dom), .ld_dow(ld_dow), .advance(advance),
      .cur_month(cur_month), .cur_dom(cur_dom), .cur_dow(cur_dow), .cur_valid(cur_valid),
      .nxt_month(nxt_month), .nxt_dom(nxt_dom), .nxt_dow(nxt_dow)
   );

   function automatic int days_of(int mo, bit lp);
      if (mo == 2) return lp ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic bit legal(int mo, int d, int w, bit lp);
      return mo >= 1 && mo <= 12 && d >= 1 && d <= days_of(mo, lp) && w >= 1 && w <= 7;
   endfunction

   task automatic chk(int act, int exp, string tag, string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d (date %0d/%0d/%0d)",
                  tag, what, act, exp, m_mon, m_dom, m_wkd);
      end
   endtask

   task automatic compare_all(string cur_tag, string nxt_override);
      bit    last;
      int    e_dom, e_mon, e_wkd;
      string t;
      last  = m_dom >= days_of(m_mon, leap);
      e_dom = last ? 1 : m_dom + 1;
      e_mon = last ? ((m_mon >= 12) ? 1 : m_mon + 1) : m_mon;
      e_wkd = (m_wkd >= 7 || m_wkd < 1) ? 1 : m_wkd + 1;
      if (nxt_override != "") t = nxt_override;
      else if (!legal(m_mon, m_dom, m_wkd, leap)) t = "R12";
      else if (last && m_mon == 12) t = "R6";
      else if (last && m_mon == 2) t = leap ? "R4" : "R3";
      else if (last) t = "R5";
      else t = "R7";
      chk(int'(cur_month), m_mon, cur_tag, "cur_month");
      chk(int'(cur_dom),   m_dom, cur_tag, "cur_dom");
      chk(int'(cur_dow),   m_wkd, cur_tag, "cur_dow");
      chk(int'(cur_valid), int'(legal(m_mon, m_dom, m_wkd, leap)), "R10", "cur_valid");
      chk(int'(nxt_dow),   e_wkd, "R2", "nxt_dow");
      chk(int'(nxt_dom),   e_dom, t, "nxt_dom");
      chk(int'(nxt_month), e_mon, t, "nxt_month");
   endtask

   // one clock: inputs set after a falling edge, results sampled at the next falling edge
   task automatic cycle(bit ld, int mo, int d, int w, bit adv, bit lp, string nxt_override);
      bit    last;
      string ct;
      load = ld; ld_month = 4'(mo); ld_dom = 5'(d); ld_dow = 3'(w);
      advance = adv; leap = lp;
      @(posedge clk);
      if (ld) begin
         m_mon = mo; m_dom = d; m_wkd = w;
         ct = "R8";
      end else begin
         ct = "R9";
         if (adv) begin
            last  = m_dom >= days_of(m_mon, lp);
            m_wkd = (m_wkd >= 7 || m_wkd < 1) ? 1 : m_wkd + 1;
            m_mon = last ? ((m_mon >= 12) ? 1 : m_mon + 1) : m_mon;
            m_dom = last ? 1 : m_dom + 1;
         end
      end
      @(negedge clk);
      load = 1'b0; advance = 1'b0;
      compare_all(ct, nxt_override);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      compare_all("R1", "");

      // R2 weekday wheel over all values, under two unrelated month/day contexts
      for (int w = 1; w <= 7; w++) cycle(1'b1, 3, 10, w, 1'b0, 1'b0, "");
      for (int w = 1; w <= 7; w++) cycle(1'b1, 12, 31, w, 1'b0, 1'b1, "");

      // R3 R4 R5 R7: first and last day of each month, both leap settings
      for (int lp = 0; lp <= 1; lp++) begin
         for (int mo = 1; mo <= 12; mo++) begin
            cycle(1'b1, mo, 1, (mo % 7) + 1, 1'b0, 1'(lp), "");
            cycle(1'b0, 0, 0, 0, 1'b1, 1'(lp), "");
            cycle(1'b1, mo, days_of(mo, 1'(lp)), 7, 1'b0, 1'(lp), "");
            cycle(1'b0, 0, 0, 0, 1'b1, 1'(lp), "");
         end
      end

      // R6 year end
      cycle(1'b1, 12, 31, 6, 1'b0, 1'b0, "");
      cycle(1'b0, 0, 0, 0, 1'b1, 1'b0, "");

      // R8 load and advance together: load must win
      cycle(1'b1, 12, 31, 7, 1'b0, 1'b0, "");
      cycle(1'b1, 5, 5, 3, 1'b1, 1'b0, "");

      // R9 idle cycles hold the date
      for (int i = 0; i < 3; i++) cycle(1'b0, 9, 9, 2, 1'b0, 1'b0, "");

      // R11 leap toggled on a held Feb 28 changes the next date in the same cycle
      cycle(1'b1, 2, 28, 4, 1'b0, 1'b0, "");
      cycle(1'b0, 0, 0, 0, 1'b0, 1'b1, "R11");
      cycle(1'b0, 0, 0, 0, 1'b0, 1'b0, "R11");

      // R10 R12 illegal dates, each then stepped once
      cycle(1'b1, 0, 5, 2, 1'b0, 1'b0, "");  cycle(1'b0, 0, 0, 0, 1'b1, 1'b0, "");
      cycle(1'b1, 13, 1, 1, 1'b0, 1'b0, ""); cycle(1'b0, 0, 0, 0, 1'b1, 1'b0, "");
      cycle(1'b1, 15, 31, 1, 1'b0, 1'b0, "");cycle(1'b0, 0, 0, 0, 1'b1, 1'b0, "");
      cycle(1'b1, 2, 29, 1, 1'b0, 1'b0, "");  cycle(1'b0, 0, 0, 0, 1'b1, 1'b0, "");
      cycle(1'b1, 2, 30, 1, 1'b0, 1'b1, "");  cycle(1'b0, 0, 0, 0, 1'b1, 1'b1, "");
      cycle(1'b1, 4, 31, 1, 1'b0, 1'b0, "");  cycle(1'b0, 0, 0, 0, 1'b1, 1'b0, "");
      cycle(1'b1, 6, 0, 3, 1'b0, 1'b0, "");   cycle(1'b0, 0, 0, 0, 1'b1, 1'b0, "");
      cycle(1'b1, 7, 7, 0, 1'b0, 1'b0, "");   cycle(1'b0, 0, 0, 0, 1'b1, 1'b0, "");

      // R9 a leap year and a common year, day after day
      cycle(1'b1, 1, 1, 1, 1'b0, 1'b1, "");
      for (int i = 0; i < 366; i++) cycle(1'b0, 0, 0, 0, 1'b1, 1'b1, "");
      for (int i = 0; i < 365; i++) cycle(1'b0, 0, 0, 0, 1'b1, 1'b0, "");
      chk(int'(cur_month), 1, "R9", "year-run month");
      chk(int'(cur_dom),   1, "R9", "year-run day");

      // R1 reset from a mid-year date
      cycle(1'b1, 8, 17, 5, 1'b0, 1'b0, "");
      rst = 1'b1;
      @(posedge clk);
      m_mon = 1; m_dom = 1; m_wkd = 1;
      @(negedge clk);
      rst = 1'b0;
      compare_all("R1", "");

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule